// File: doc/BRIEF.md
# AUX Channel Transfer Engine

This block runs one request/reply exchange on a display auxiliary channel. Software loads up to twenty request bytes into five 32-bit data words and then writes the control word with the busy bit set. The engine first drives a sync phase, whose length is counted in bit-clock ticks. It then hands the request bytes one at a time to a serializer over a valid/ready byte handshake. After that it waits for reply bytes from the deserializer.

Reply bytes land in the same data words, with the same packing as the request. The transfer ends in one of two ways: the deserializer marks the end of the reply, or the line stays silent for the selected timeout. The engine then records how many reply bytes came back, raises done and any error flag, drops busy, and can pulse an interrupt. The line coding itself lives outside the block.

Top module: `aux_xfer_engine`

Register map. Address 0 is the control word. Addresses 1 to 5 are data words 0 to 4. The control word fields are:
- bit 31: busy
- bit 30: done
- bit 29: interrupt enable
- bit 28: timeout error
- bit 27: reply error
- bits 26:25: timeout select
- bit 24: fast sync
- bits 20:16: size
- bits 11:8: extra precharge, read-only
- bits 7:0: bit-clock divider, read-only

## Requirements
- R1: Byte k of a message sits in data word k/4 (address 1 + k/4). Within that word it occupies bits [31-8*(k%4) -: 8], so the first byte is in bits 31:24. On a start, the engine sends bytes 0 to N-1 in order on txByte, where N is the size field and values above 20 are treated as 20. txLast marks byte N-1.
- R2: After a start, lineSync stays high for exactly SYNC ticks and no byte is offered during that time. SYNC is 32 (16 precharge + 16 preamble), or 24 (16 + 8) when fast sync (bit 24) is set. One tick lasts DIV = round(CLK_KHZ/2000) clocks. Control bits 7:0 read DIV, and bits 11:8 read the extra precharge (32-10-16)/2 = 3.
- R3: Writing 1 to bit 31 while idle starts a transfer. Bit 31 reads 1 until the transfer completes, and it falls in the same cycle that done (bit 30) rises.
- R4: During the wait phase, reply byte k is stored with the R1 packing. Data bytes that are not replied to keep their old values. On completion, the size field (bits 20:16) reads the received count.
- R5: A reply that ends with 0 bytes sets the reply error flag (bit 27). So does a reply of more than 20 bytes: in that case only the first 20 bytes are stored and the size field reads 21.
- R6: Timeout select (bits 26:25) values 0, 1, 2 and 3 give 400, 600, 800 and 1600 µs. The timer counts from the end of sending and restarts on each reply byte. If it expires, the engine sets the timeout error flag (bit 28) and done, and clears busy.
- R7: Done, timeout error and reply error are each cleared by writing 1 to them while idle. Writing 0 to them has no effect.
- R8: While busy, writes to the data words and to the control word are ignored.
- R9: irq pulses for one cycle, together with the rise of done, only if interrupt enable (bit 29) is set.
- R10: After reset the engine is idle and all flags are clear. The control word reads 0x00000304 for the default 8000 kHz clock, and txValid, lineSync and irq are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address: 0 is control, 1 to 5 are data words |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational) |
| lineSync | output | 1 | Sync/precharge phase active |
| txValid | output | 1 | Request byte offered to the serializer |
| txByte | output | 8 | Request byte |
| txLast | output | 1 | Offered byte is the last of the request |
| txReady | input | 1 | Serializer accepts the byte this cycle |
| rxValid | input | 1 | Reply byte present |
| rxByte | input | 8 | Reply byte |
| rxEnd | input | 1 | End of reply (may come with the last byte) |
| irq | output | 1 | Completion interrupt pulse |

## Verification
The request path is tried with a six-byte message that spans two words, which separates correct big-endian packing from swapped or shifted lanes. A one-byte message then tests the fast-sync count against the normal one. Replies cover five cases, each separating a different fault:
- A short three-byte reply shows that untouched bytes keep their values.
- An empty reply and a 21-byte reply tell legal sizes from illegal ones and show the overflow cap.
- A reply split by long gaps separates a timer that restarts on each byte from one that does not.
- Total silence with the 600 µs and 1600 µs settings measures the timeout length. The 1600 µs run also exposes a control write that wrongly lands while busy.

// File: rtl/aux_xfer_pkg.sv
package aux_xfer_pkg;
  localparam int NUM_WORDS      = 5;
  localparam int BYTES_PER_WORD = 4;
  localparam int MAX_BYTES      = NUM_WORDS * BYTES_PER_WORD;
  localparam int CNT_W          = $clog2(MAX_BYTES + 2);
  localparam int WORD_SEL_W     = CNT_W - 2;

  // control word field positions
  localparam int BIT_BUSY  = 31;
  localparam int BIT_DONE  = 30;
  localparam int BIT_IRQEN = 29;
  localparam int BIT_TOERR = 28;
  localparam int BIT_RXERR = 27;
  localparam int BIT_TOSEL = 25;
  localparam int BIT_FAST  = 24;
  localparam int BIT_SIZE  = 16;

  typedef enum logic [1:0] {ST_IDLE, ST_SYNC, ST_SEND, ST_WAIT} auxState_t;

  typedef struct packed {
    logic             doneSet;
    logic             toErrSet;
    logic             rxErrSet;
    logic             rxWr;
    logic [CNT_W-1:0] rxIdx;
    logic [CNT_W-1:0] rxCount;
  } auxStrobe_t;
endpackage

// File: rtl/aux_xfer_ctl.sv
module aux_xfer_ctl
  import aux_xfer_pkg::*;
#(
  parameter int DIV       = 4,
  parameter int SYNC_NORM = 32,
  parameter int SYNC_FAST = 24,
  parameter int TO_CYC0   = 3200,
  parameter int TO_CYC1   = 4800,
  parameter int TO_CYC2   = 6400,
  parameter int TO_CYC3   = 12800
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [CNT_W-1:0] sendCnt,
  input  logic             fastSync,
  input  logic [1:0]       toSel,
  input  logic             txReady,
  input  logic             rxValid,
  input  logic             rxEnd,
  output logic             busy,
  output logic             lineSync,
  output logic             txValid,
  output logic             txLast,
  output logic [CNT_W-1:0] txIdx,
  output auxStrobe_t       strobe
);
  localparam int DIV_W  = $clog2(DIV + 1);
  localparam int SYNC_W = $clog2(SYNC_NORM + SYNC_FAST + 1);
  localparam int TO_MAX = (TO_CYC3 > TO_CYC2) ? TO_CYC3 : TO_CYC2;
  localparam int TO_W   = $clog2(TO_MAX + 1);

  auxState_t         state;
  logic [DIV_W-1:0]  divCnt;
  logic [SYNC_W-1:0] syncCnt;
  logic [CNT_W-1:0]  idx;
  logic [TO_W-1:0]   toCnt;
  logic [CNT_W-1:0]  rxCnt;

  logic              bitTick;
  logic [SYNC_W-1:0] syncLast;
  logic [CNT_W-1:0]  effCnt;
  logic              lastByte;
  logic [TO_W-1:0]   toLim;
  logic              toHit;
  logic [CNT_W-1:0]  rxNext;
  logic              inWait;

  assign bitTick  = (divCnt == DIV_W'(DIV - 1));
  assign syncLast = fastSync ? SYNC_W'(SYNC_FAST - 1) : SYNC_W'(SYNC_NORM - 1);
  assign effCnt   = (sendCnt > CNT_W'(MAX_BYTES)) ? CNT_W'(MAX_BYTES) : sendCnt;
  assign lastByte = (idx == effCnt - 1'b1);
  assign inWait   = (state == ST_WAIT);

  always_comb begin
    case (toSel)
      2'd0:    toLim = TO_W'(TO_CYC0);
      2'd1:    toLim = TO_W'(TO_CYC1);
      2'd2:    toLim = TO_W'(TO_CYC2);
      default: toLim = TO_W'(TO_CYC3);
    endcase
  end

  assign toHit  = inWait && !rxValid && !rxEnd && (toCnt == toLim - 1'b1);
  assign rxNext = (rxValid && rxCnt <= CNT_W'(MAX_BYTES)) ? rxCnt + 1'b1 : rxCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      divCnt  <= '0;
      syncCnt <= '0;
      idx     <= '0;
      toCnt   <= '0;
      rxCnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state   <= ST_SYNC;
          divCnt  <= '0;
          syncCnt <= '0;
          idx     <= '0;
          rxCnt   <= '0;
        end
        ST_SYNC: begin
          divCnt <= bitTick ? '0 : divCnt + 1'b1;
          if (bitTick) begin
            syncCnt <= syncCnt + 1'b1;
            if (syncCnt == syncLast) begin
              state <= (effCnt == '0) ? ST_WAIT : ST_SEND;
              toCnt <= '0;
            end
          end
        end
        ST_SEND: if (txReady) begin
          idx <= idx + 1'b1;
          if (lastByte) begin
            state <= ST_WAIT;
            toCnt <= '0;
          end
        end
        default: begin
          rxCnt <= rxNext;
          toCnt <= rxValid ? '0 : toCnt + 1'b1;
          if (rxEnd || toHit) state <= ST_IDLE;
        end
      endcase
    end
  end

  assign busy     = (state != ST_IDLE);
  assign lineSync = (state == ST_SYNC);
  assign txValid  = (state == ST_SEND);
  assign txLast   = txValid && lastByte;
  assign txIdx    = idx;

  always_comb begin
    strobe          = '0;
    strobe.doneSet  = inWait && (rxEnd || toHit);
    strobe.toErrSet = toHit;
    strobe.rxErrSet = inWait && rxEnd && (rxNext == '0 || rxNext > CNT_W'(MAX_BYTES));
    strobe.rxWr     = inWait && rxValid && (rxCnt < CNT_W'(MAX_BYTES));
    strobe.rxIdx    = rxCnt;
    strobe.rxCount  = rxNext;
  end

  // R2: sync phase and byte offers never overlap
  a_r2_sync_excl: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({lineSync, txValid}));
  // R3: completion is only reported for a running transfer
  a_r3_done_in_busy: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doneSet |-> busy);
  // R5: received count saturates one above the maximum
  a_r5_count_cap: assert property (@(posedge clk) disable iff (!rstN)
    rxCnt <= CNT_W'(MAX_BYTES + 1));
  // R6: timeout error implies the line was silent in that cycle
  a_r6_timeout_quiet: assert property (@(posedge clk) disable iff (!rstN)
    strobe.toErrSet |-> (!rxValid && !rxEnd));
endmodule

// File: rtl/aux_xfer_dp.sv
module aux_xfer_dp
  import aux_xfer_pkg::*;
#(
  parameter logic [7:0] DIV_FIELD = 8'd4,
  parameter logic [3:0] PRE_FIELD = 4'd3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWr,
  input  logic [2:0]       regAddr,
  input  logic [31:0]      regWrData,
  output logic [31:0]      regRdData,
  input  logic             busy,
  input  logic [CNT_W-1:0] txIdx,
  input  auxStrobe_t       strobe,
  input  logic [7:0]       rxByte,
  output logic             start,
  output logic [CNT_W-1:0] sendCnt,
  output logic             fastSync,
  output logic [1:0]       toSel,
  output logic [7:0]       txByte,
  output logic             irq
);
  logic [NUM_WORDS-1:0][31:0] words;
  logic doneF, toErrF, rxErrF, irqEn;
  logic [CNT_W-1:0] sizeF;
  logic ctrlWr;

  assign ctrlWr = regWr && (regAddr == 3'd0) && !busy;
  assign start  = ctrlWr && regWrData[BIT_BUSY];
  assign sendCnt = sizeF;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneF    <= 1'b0;
      toErrF   <= 1'b0;
      rxErrF   <= 1'b0;
      irqEn    <= 1'b0;
      toSel    <= '0;
      fastSync <= 1'b0;
      sizeF    <= '0;
      irq      <= 1'b0;
    end else begin
      irq <= strobe.doneSet && irqEn;
      if (ctrlWr) begin
        irqEn    <= regWrData[BIT_IRQEN];
        toSel    <= regWrData[BIT_TOSEL +: 2];
        fastSync <= regWrData[BIT_FAST];
        sizeF    <= regWrData[BIT_SIZE +: CNT_W];
        if (regWrData[BIT_DONE])  doneF  <= 1'b0;
        if (regWrData[BIT_TOERR]) toErrF <= 1'b0;
        if (regWrData[BIT_RXERR]) rxErrF <= 1'b0;
      end
      if (strobe.doneSet) begin
        doneF <= 1'b1;
        sizeF <= strobe.rxCount;
      end
      if (strobe.toErrSet) toErrF <= 1'b1;
      if (strobe.rxErrSet) rxErrF <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      words <= '0;
    end else begin
      for (int w = 0; w < NUM_WORDS; w++) begin
        if (regWr && !busy && regAddr == 3'(w + 1))
          words[w] <= regWrData;
        else if (strobe.rxWr && strobe.rxIdx[CNT_W-1:2] == WORD_SEL_W'(w))
          words[w][{~strobe.rxIdx[1:0], 3'b000} +: 8] <= rxByte;
      end
    end
  end

  always_comb begin
    txByte = '0;
    for (int w = 0; w < NUM_WORDS; w++)
      if (txIdx[CNT_W-1:2] == WORD_SEL_W'(w))
        txByte = words[w][{~txIdx[1:0], 3'b000} +: 8];
  end

  always_comb begin
    regRdData = '0;
    if (regAddr == 3'd0) begin
      regRdData[BIT_BUSY]            = busy;
      regRdData[BIT_DONE]            = doneF;
      regRdData[BIT_IRQEN]           = irqEn;
      regRdData[BIT_TOERR]           = toErrF;
      regRdData[BIT_RXERR]           = rxErrF;
      regRdData[BIT_TOSEL +: 2]      = toSel;
      regRdData[BIT_FAST]            = fastSync;
      regRdData[BIT_SIZE +: CNT_W]   = sizeF;
      regRdData[11:8]                = PRE_FIELD;
      regRdData[7:0]                 = DIV_FIELD;
    end else begin
      for (int w = 0; w < NUM_WORDS; w++)
        if (regAddr == 3'(w + 1)) regRdData = words[w];
    end
  end

  // R3: busy only drops when done is reported
  a_r3_busy_fall_done: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> doneF);
  // R8: data words only change during a transfer through reply writes
  a_r8_data_hold: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !strobe.rxWr) |=> $stable(words));
  // R9: interrupt only with done set and enabled
  a_r9_irq_done: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (doneF && irqEn));
endmodule

// File: rtl/aux_xfer_engine.sv
module aux_xfer_engine
  import aux_xfer_pkg::*;
#(
  parameter int CLK_KHZ   = 8000,
  parameter int PRECHARGE = 16,
  parameter int PREAMBLE  = 16,
  parameter int FAST_PRE  = 8,
  parameter int PRE_MIN   = 10,
  parameter int TO_US0    = 400,
  parameter int TO_US1    = 600,
  parameter int TO_US2    = 800,
  parameter int TO_US3    = 1600
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWr,
  input  logic [2:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic        lineSync,
  output logic        txValid,
  output logic [7:0]  txByte,
  output logic        txLast,
  input  logic        txReady,
  input  logic        rxValid,
  input  logic [7:0]  rxByte,
  input  logic        rxEnd,
  output logic        irq
);
  localparam int DIV_RAW   = (CLK_KHZ + 1000) / 2000;
  localparam int DIV       = (DIV_RAW < 1) ? 1 : DIV_RAW;
  localparam int US_RAW    = CLK_KHZ / 1000;
  localparam int US_CYC    = (US_RAW < 1) ? 1 : US_RAW;
  localparam int SYNC_NORM = PRECHARGE + PREAMBLE;
  localparam int SYNC_FAST = PRECHARGE + FAST_PRE;
  localparam int EXTRA_PRE = (SYNC_NORM - PRE_MIN - PREAMBLE) / 2;

  logic             busy, start, fastSync;
  logic [CNT_W-1:0] sendCnt, txIdx;
  logic [1:0]       toSel;
  auxStrobe_t       strobe;

  aux_xfer_ctl #(
    .DIV(DIV), .SYNC_NORM(SYNC_NORM), .SYNC_FAST(SYNC_FAST),
    .TO_CYC0(TO_US0 * US_CYC), .TO_CYC1(TO_US1 * US_CYC),
    .TO_CYC2(TO_US2 * US_CYC), .TO_CYC3(TO_US3 * US_CYC)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .start(start), .sendCnt(sendCnt),
    .fastSync(fastSync), .toSel(toSel), .txReady(txReady),
    .rxValid(rxValid), .rxEnd(rxEnd), .busy(busy), .lineSync(lineSync),
    .txValid(txValid), .txLast(txLast), .txIdx(txIdx), .strobe(strobe)
  );

  aux_xfer_dp #(
    .DIV_FIELD(8'(DIV)), .PRE_FIELD(4'(EXTRA_PRE))
  ) u_dp (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .busy(busy),
    .txIdx(txIdx), .strobe(strobe), .rxByte(rxByte), .start(start),
    .sendCnt(sendCnt), .fastSync(fastSync), .toSel(toSel),
    .txByte(txByte), .irq(irq)
  );
endmodule

// File: tb/sim_aux_xfer_engine.sv
module sim_aux_xfer_engine;
  localparam int CLK_PERIOD = 10;
  localparam int CYC_600    = 4800;
  localparam int CYC_1600   = 12800;

  logic clk = 1'b0, rstN = 1'b0;
  logic regWr = 1'b0;
  logic [2:0] regAddr = 3'd0;
  logic [31:0] regWrData = '0, regRdData;
  logic lineSync, txValid, txLast, irq;
  logic [7:0] txByte;
  logic txReady = 1'b1, rxValid = 1'b0, rxEnd = 1'b0;
  logic [7:0] rxByte = '0;

  int total = 0, bad = 0;
  int cyc = 0, acceptCyc = 0, syncHigh = 0, irqCount = 0, txCount = 0;
  logic [7:0] expQ[$];
  logic lastSeen;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  aux_xfer_engine u0 (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .lineSync(lineSync),
    .txValid(txValid), .txByte(txByte), .txLast(txLast), .txReady(txReady),
    .rxValid(rxValid), .rxByte(rxByte), .rxEnd(rxEnd), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // monitor: scoreboard for offered bytes, plus sync/irq counters
  always @(negedge clk) begin
    if (lineSync) syncHigh++;
    if (irq) irqCount++;
    if (txValid && txReady) begin
      txCount++;
      acceptCyc = cyc;
      lastSeen = txLast;
      if (expQ.size() == 0) check(1'b0, "R1 unexpected byte", {24'd0, txByte}, 32'd0);
      else begin
        logic [7:0] e;
        e = expQ.pop_front();
        check(txByte == e, "R1 byte order", {24'd0, txByte}, {24'd0, e});
        check(txLast == (expQ.size() == 0), "R1 last marker", {31'd0, txLast}, {31'd0, expQ.size() == 0});
      end
    end
  end

  task automatic regWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWr = 1'b0; regAddr = 3'd0; regWrData = '0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
    regAddr = 3'd0;
  endtask

  task automatic waitSent();
    while (expQ.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic waitIdle();
    @(negedge clk);
    while (regRdData[31]) @(negedge clk);
  endtask

  task automatic sendReply(input int n, input int base, input bit withEnd);
    if (n == 0) begin
      @(negedge clk); rxEnd = withEnd;
      @(negedge clk); rxEnd = 1'b0;
    end
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rxValid = 1'b1; rxByte = 8'(base + i); rxEnd = withEnd && (i == n - 1);
    end
    if (n != 0) begin
      @(negedge clk);
      rxValid = 1'b0; rxEnd = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired act=%0d exp=0", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int waitCyc;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R10 reset state
    regRead(3'd0, r);
    check(r == 32'h0000_0304, "R10 reset ctrl", r, 32'h0000_0304);
    check(!txValid && !lineSync && !irq, "R10 reset outputs", {29'd0, txValid, lineSync, irq}, 32'd0);

    // Test A: six-byte request spanning two words, irq enabled
    regWrite(3'd1, 32'hA1B2_C3D4);
    regWrite(3'd2, 32'hE5F6_0000);
    expQ = '{8'hA1, 8'hB2, 8'hC3, 8'hD4, 8'hE5, 8'hF6};
    syncHigh = 0; txCount = 0; irqCount = 0;
    regWrite(3'd0, 32'hA006_0000);
    waitSent();
    check(txCount == 6, "R1 byte count", txCount, 6);
    check(syncHigh == 128, "R2 normal sync length", syncHigh, 128);
    regRead(3'd0, r);
    check(r[31] == 1'b1, "R3 busy held while waiting", {31'd0, r[31]}, 1);
    sendReply(3, 'h00 + 0, 1'b0 ? 1'b0 : 1'b0);
    sendReply(0, 0, 1'b1);
    regRead(3'd0, r);
    check(r == 32'h6003_0304, "R4 R3 completion ctrl", r, 32'h6003_0304);
    regRead(3'd1, r);
    check(r == 32'h0001_02D4, "R4 reply packing", r, 32'h0001_02D4);
    check(irqCount == 1, "R9 irq with enable", irqCount, 1);

    // R7: writing zero to done has no effect, writing one clears
    regWrite(3'd0, 32'h2003_0000);
    regRead(3'd0, r);
    check(r == 32'h6003_0304, "R7 zero write keeps done", r, 32'h6003_0304);
    regWrite(3'd0, 32'h4000_0000);
    regRead(3'd0, r);
    check(r == 32'h0000_0304, "R7 one clears done", r, 32'h0000_0304);

    // Test C: fast sync, 600us timeout, data write while busy
    regWrite(3'd1, 32'h5500_0000);
    regWrite(3'd5, 32'h1234_5678);
    expQ = '{8'h55};
    syncHigh = 0; irqCount = 0;
    regWrite(3'd0, 32'h8301_0000);
    waitSent();
    check(syncHigh == 96, "R2 fast sync length", syncHigh, 96);
    regWrite(3'd5, 32'hDEAD_BEEF);
    waitIdle();
    waitCyc = cyc - acceptCyc - 1;
    check(waitCyc >= CYC_600 - 2 && waitCyc <= CYC_600 + 2, "R6 600us timeout", waitCyc, CYC_600);
    regRead(3'd0, r);
    check(r == 32'h5300_0304, "R6 timeout flags", r, 32'h5300_0304);
    regRead(3'd5, r);
    check(r == 32'h1234_5678, "R8 data write ignored while busy", r, 32'h1234_5678);
    check(irqCount == 0, "R9 no irq when disabled", irqCount, 0);

    // Test D: timer restarts on each reply byte (400us setting)
    regWrite(3'd1, 32'h7700_0000);
    expQ = '{8'h77};
    regWrite(3'd0, 32'hD801_0000);
    waitSent();
    repeat (3000) @(negedge clk);
    sendReply(1, 'hA0, 1'b0);
    repeat (3000) @(negedge clk);
    regRead(3'd0, r);
    check(r[31] == 1'b1 && r[28] == 1'b0, "R6 timer restarts on byte", {30'd0, r[31], r[28]}, 32'h2);
    sendReply(1, 'hA1, 1'b1);
    regRead(3'd0, r);
    check(r == 32'h4002_0304, "R6 R4 late reply accepted", r, 32'h4002_0304);
    regRead(3'd1, r);
    check(r == 32'hA0A1_0000, "R4 two reply bytes", r, 32'hA0A1_0000);

    // Test E: empty reply is an error
    regWrite(3'd1, 32'h6600_0000);
    expQ = '{8'h66};
    regWrite(3'd0, 32'hD801_0000);
    waitSent();
    sendReply(0, 0, 1'b1);
    regRead(3'd0, r);
    check(r == 32'h4800_0304, "R5 empty reply error", r, 32'h4800_0304);

    // Test F: 21-byte reply overflows
    regWrite(3'd1, 32'h6600_0000);
    expQ = '{8'h66};
    regWrite(3'd0, 32'hD801_0000);
    waitSent();
    sendReply(21, 'h80, 1'b1);
    regRead(3'd0, r);
    check(r == 32'h4815_0304, "R5 overflow error and size", r, 32'h4815_0304);
    regRead(3'd1, r);
    check(r == 32'h8081_8283, "R5 first word stored", r, 32'h8081_8283);
    regRead(3'd5, r);
    check(r == 32'h9091_9293, "R5 twentieth byte kept, extra dropped", r, 32'h9091_9293);

    // Test G: max timeout, control write while busy ignored
    regWrite(3'd1, 32'h3300_0000);
    expQ = '{8'h33};
    regWrite(3'd0, 32'hDE01_0000);
    waitSent();
    regWrite(3'd0, 32'h0000_0000);
    waitIdle();
    waitCyc = cyc - acceptCyc - 1;
    check(waitCyc >= CYC_1600 - 2 && waitCyc <= CYC_1600 + 2, "R6 R8 max timeout kept", waitCyc, CYC_1600);
    regRead(3'd0, r);
    check(r == 32'h5600_0304, "R8 ctrl write ignored while busy", r, 32'h5600_0304);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule